// File: doc/BRIEF.md
# Variable-Size Block Allocator

This block hands out and takes back contiguous regions of a word-addressed pool that holds a lookup database. A trie node grows or shrinks as keys are added or removed, so the database keeps asking for blocks of one to `MAX_REQ` words and returning blocks it no longer needs. All free space is tracked on chip in a small table of free extents. An allocation takes the smallest free extent that is large enough, and a release joins the returned region with any free extent that touches it. One operation is handled at a time, and each one finishes in a fixed, short number of cycles.

Requests arrive on a valid/ready channel. `req_ready` is high only when the block is idle and is not presenting a result in that cycle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The requester must hold `req_valid` and all request fields steady until that edge. No queue sits at the input, so back-pressure lasts exactly as long as the operation in flight. Each accepted request produces exactly one single-cycle `done` pulse, which carries the result base address and two flags: `done_fail` and `done_err`.

The replace operation serves the common key-update case. It releases the old block and then allocates the new block as one step, and the new block may reuse the space that was just released.

Top module: `blk_alloc`

## Requirements
- R1: After reset the whole pool of `POOL_WORDS` words is a single free extent, so the first legal allocation returns base 0.
- R2: `req_ready` is high only when idle and `done` is low. It drops in the cycle after a request is accepted. Every accepted request gives exactly one `done` pulse, one cycle long.
- R3: The code on `req_op` selects the operation: 0 allocates, 1 releases, 2 replaces, and 3 is an error. An allocate or replace whose `req_asize` is 0 or greater than `MAX_REQ` is also an error. An error raises `done_err` and changes no state.
- R4: A release or replace is an error (`done_err`, no state change) when `req_fsize` is 0, when `req_fsize` exceeds `MAX_REQ`, or when `req_base + req_fsize` exceeds `POOL_WORDS`.
- R5: An allocation is served from the smallest free extent that holds `req_asize` words. A tie goes to the extent with the lowest base. The block is cut from the low end of that extent, and the rest of the extent stays free.
- R6: When no free extent is large enough, `done_fail` is raised and all free-space state stays as it was.
- R7: A released region is joined with the free extent that ends at its base and with the free extent that starts at its end, so free space always forms maximal runs.
- R8: A replace first releases (`req_base`, `req_fsize`) and then allocates `req_asize`, and the allocation may use the released space. If the allocation part fails, the release is undone as well.
- R9: `done_base` carries the new block's base on a successful allocate or replace, and the released base on a release. It is 0 whenever `done_err` or `done_fail` is set.
- R10: `done` comes 1 cycle after acceptance for an error, 2 cycles after for an allocate or a release, and 3 cycles after for a replace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | Operation code (0 allocate, 1 release, 2 replace, 3 invalid) |
| req_base | input | $clog2(POOL_WORDS) | Base of the region to release |
| req_fsize | input | $clog2(MAX_REQ+1) | Size of the region to release |
| req_asize | input | $clog2(MAX_REQ+1) | Size to allocate |
| done | output | 1 | One-cycle result strobe |
| done_base | output | $clog2(POOL_WORDS) | Result base address |
| done_fail | output | 1 | No free extent was large enough |
| done_err | output | 1 | Request was malformed |

## Verification
A wrong free-extent table stays hidden until a later allocation depends on it. At that point it shows up as a wrong `done_base`, a `done_fail` where space existed, or an overlap. The bench therefore keeps a word-level free map and compares every result against the base that map predicts. A corruption is caught on the first allocation whose best-fit choice it changes, which under the random mix is usually within a few operations. Missed merges show up as spurious failures once the pool is nearly full, and the fill-to-exhaustion and failed-replace sequences drive it there on purpose.

// File: rtl/blk_alloc_pkg.sv
package blk_alloc_pkg;

  typedef enum logic [1:0] {
    OP_ALLOC = 2'b00,
    OP_FREE  = 2'b01,
    OP_SWAP  = 2'b10,
    OP_BAD   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_MERGE = 2'b01,
    ST_FIT   = 2'b10
  } st_e;

endpackage

// File: rtl/blk_alloc_nbr.sv
// Finds the free extents that touch a region being released, and the first empty slot.
module blk_alloc_nbr #(
  parameter int NBLK = 32,
  parameter int W    = 7,
  parameter int IW   = 5
) (
  input  logic [NBLK-1:0]        v_i,
  input  logic [NBLK-1:0][W-1:0] base_i,
  input  logic [NBLK-1:0][W-1:0] size_i,
  input  logic [W-1:0]           fb_i,
  input  logic [W-1:0]           fs_i,
  output logic                   lo_hit_o,
  output logic [IW-1:0]          lo_idx_o,
  output logic                   hi_hit_o,
  output logic [IW-1:0]          hi_idx_o,
  output logic                   slot_hit_o,
  output logic [IW-1:0]          slot_idx_o
);
  logic [W:0]      rel_end;
  logic [NBLK-1:0] lo_m, hi_m;

  assign rel_end = (W+1)'(fb_i) + (W+1)'(fs_i);

  for (genvar g = 0; g < NBLK; g++) begin : g_match
    logic [W:0] ext_end;
    assign ext_end = (W+1)'(base_i[g]) + (W+1)'(size_i[g]);
    assign lo_m[g] = v_i[g] && (ext_end == (W+1)'(fb_i));
    assign hi_m[g] = v_i[g] && ((W+1)'(base_i[g]) == rel_end);
  end

  always_comb begin
    lo_hit_o = 1'b0; lo_idx_o = '0;
    hi_hit_o = 1'b0; hi_idx_o = '0;
    slot_hit_o = 1'b0; slot_idx_o = '0;
    for (int i = 0; i < NBLK; i++) begin
      if (lo_m[i] && !lo_hit_o) begin
        lo_hit_o = 1'b1; lo_idx_o = IW'(i);
      end
      if (hi_m[i] && !hi_hit_o) begin
        hi_hit_o = 1'b1; hi_idx_o = IW'(i);
      end
      if (!v_i[i] && !slot_hit_o) begin
        slot_hit_o = 1'b1; slot_idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/blk_alloc_fit.sv
// Best-fit pick: smallest extent that fits, lowest base on a tie.
module blk_alloc_fit #(
  parameter int NBLK = 32,
  parameter int W    = 7,
  parameter int IW   = 5
) (
  input  logic [NBLK-1:0]        v_i,
  input  logic [NBLK-1:0][W-1:0] base_i,
  input  logic [NBLK-1:0][W-1:0] size_i,
  input  logic [W-1:0]           need_i,
  output logic                   hit_o,
  output logic [IW-1:0]          idx_o
);
  logic [NBLK-1:0] fits;

  for (genvar g = 0; g < NBLK; g++) begin : g_fits
    assign fits[g] = v_i[g] && (size_i[g] >= need_i);
  end

  always_comb begin
    logic [W-1:0] best_sz, best_b;
    hit_o   = 1'b0;
    idx_o   = '0;
    best_sz = '0;
    best_b  = '0;
    for (int i = 0; i < NBLK; i++) begin
      if (fits[i] && (!hit_o || size_i[i] < best_sz ||
                      (size_i[i] == best_sz && base_i[i] < best_b))) begin
        hit_o   = 1'b1;
        idx_o   = IW'(i);
        best_sz = size_i[i];
        best_b  = base_i[i];
      end
    end
  end
endmodule

// File: rtl/blk_alloc.sv
module blk_alloc
  import blk_alloc_pkg::*;
#(
  parameter int POOL_WORDS = 64,
  parameter int MAX_REQ    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [1:0]                      req_op,
  input  logic [$clog2(POOL_WORDS)-1:0]   req_base,
  input  logic [$clog2(MAX_REQ+1)-1:0]    req_fsize,
  input  logic [$clog2(MAX_REQ+1)-1:0]    req_asize,
  output logic                            done,
  output logic [$clog2(POOL_WORDS)-1:0]   done_base,
  output logic                            done_fail,
  output logic                            done_err
);
  localparam int AW   = $clog2(POOL_WORDS);
  localparam int W    = $clog2(POOL_WORDS + 1);
  localparam int RW   = $clog2(MAX_REQ + 1);
  localparam int NBLK = (POOL_WORDS + 1) / 2;
  localparam int IW   = (NBLK > 1) ? $clog2(NBLK) : 1;
  localparam int TW   = W + IW;

  st_e  st;
  op_e  op_q;
  logic [W-1:0] asz_q, fb_q, fs_q;

  // committed free-extent table and the working copy of one operation
  logic [NBLK-1:0]        tv, wv, mv, sv;
  logic [NBLK-1:0][W-1:0] tb, ts, wb, ws, mb, ms, sb, ss;

  // request decode
  op_e        op_in;
  logic [W:0] rel_end;
  logic       a_bad, f_bad, req_bad, accept;

  assign op_in   = op_e'(req_op);
  assign rel_end = (W+1)'(req_base) + (W+1)'(req_fsize);
  assign a_bad   = (req_asize == '0) || (req_asize > RW'(MAX_REQ));
  assign f_bad   = (req_fsize == '0) || (req_fsize > RW'(MAX_REQ)) ||
                   (rel_end > (W+1)'(POOL_WORDS));
  assign req_bad = (op_in == OP_BAD) || ((op_in != OP_FREE) && a_bad) ||
                   ((op_in != OP_ALLOC) && f_bad);
  assign req_ready = (st == ST_IDLE) && !done;
  assign accept    = req_valid && req_ready;

  // neighbour search and merge
  logic          lo_hit, hi_hit, slot_hit;
  logic [IW-1:0] lo_idx, hi_idx, slot_idx;

  blk_alloc_nbr #(.NBLK(NBLK), .W(W), .IW(IW)) u_nbr (
    .v_i(wv), .base_i(wb), .size_i(ws), .fb_i(fb_q), .fs_i(fs_q),
    .lo_hit_o(lo_hit), .lo_idx_o(lo_idx), .hi_hit_o(hi_hit), .hi_idx_o(hi_idx),
    .slot_hit_o(slot_hit), .slot_idx_o(slot_idx)
  );

  always_comb begin
    mv = wv; mb = wb; ms = ws;
    if (lo_hit && hi_hit) begin
      ms[lo_idx] = ws[lo_idx] + fs_q + ws[hi_idx];
      mv[hi_idx] = 1'b0;
    end else if (lo_hit) begin
      ms[lo_idx] = ws[lo_idx] + fs_q;
    end else if (hi_hit) begin
      mb[hi_idx] = fb_q;
      ms[hi_idx] = ws[hi_idx] + fs_q;
    end else begin
      mv[slot_idx] = 1'b1;
      mb[slot_idx] = fb_q;
      ms[slot_idx] = fs_q;
    end
  end

  // best-fit search and split
  logic          fit_hit;
  logic [IW-1:0] fit_idx;

  blk_alloc_fit #(.NBLK(NBLK), .W(W), .IW(IW)) u_fit (
    .v_i(wv), .base_i(wb), .size_i(ws), .need_i(asz_q),
    .hit_o(fit_hit), .idx_o(fit_idx)
  );

  always_comb begin
    sv = wv; sb = wb; ss = ws;
    if (fit_hit) begin
      if (ws[fit_idx] == asz_q) begin
        sv[fit_idx] = 1'b0;
      end else begin
        sb[fit_idx] = wb[fit_idx] + asz_q;
        ss[fit_idx] = ws[fit_idx] - asz_q;
      end
    end
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      op_q      <= OP_ALLOC;
      asz_q     <= '0;
      fb_q      <= '0;
      fs_q      <= '0;
      tv        <= '0;
      tb        <= '0;
      ts        <= '0;
      tv[0]     <= 1'b1;
      ts[0]     <= W'(POOL_WORDS);
      wv        <= '0;
      wb        <= '0;
      ws        <= '0;
      done      <= 1'b0;
      done_base <= '0;
      done_fail <= 1'b0;
      done_err  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            op_q  <= op_in;
            asz_q <= W'(req_asize);
            fb_q  <= W'(req_base);
            fs_q  <= W'(req_fsize);
            wv    <= tv;
            wb    <= tb;
            ws    <= ts;
            if (req_bad) begin
              done      <= 1'b1;
              done_err  <= 1'b1;
              done_fail <= 1'b0;
              done_base <= '0;
            end else begin
              st <= (op_in == OP_ALLOC) ? ST_FIT : ST_MERGE;
            end
          end
        end
        ST_MERGE: begin
          wv <= mv; wb <= mb; ws <= ms;
          if (op_q == OP_FREE) begin
            tv <= mv; tb <= mb; ts <= ms;
            done      <= 1'b1;
            done_err  <= 1'b0;
            done_fail <= 1'b0;
            done_base <= fb_q[AW-1:0];
            st        <= ST_IDLE;
          end else begin
            st <= ST_FIT;
          end
        end
        ST_FIT: begin
          done     <= 1'b1;
          done_err <= 1'b0;
          if (fit_hit) begin
            tv <= sv; tb <= sb; ts <= ss;
            done_fail <= 1'b0;
            done_base <= wb[fit_idx][AW-1:0];
          end else begin
            done_fail <= 1'b1;
            done_base <= '0;
          end
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // free word count of the committed table, used by the checks below
  logic [TW-1:0] free_total;
  always_comb begin
    free_total = '0;
    for (int i = 0; i < NBLK; i++)
      if (tv[i]) free_total = free_total + TW'(ts[i]);
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(done_err && done_fail)); // R9
  AST_FAIL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (done_fail || done_err)) |-> $stable(free_total)); // R6
  AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_total <= TW'(POOL_WORDS)); // R5
  AST_ALLOC_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_fail && !done_err && op_q != OP_FREE) |->
      ((W+1)'(done_base) + (W+1)'(asz_q) <= (W+1)'(POOL_WORDS))); // R5
  AST_FIT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FIT && fit_hit) |-> (ws[fit_idx] >= asz_q)); // R5
  AST_SLOT_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MERGE && !lo_hit && !hi_hit) |-> slot_hit); // R7
endmodule

// File: tb/blk_alloc_bench.sv
module blk_alloc_bench;
  localparam int M  = 64;
  localparam int MX = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = '0;
  logic [5:0] req_base = '0;
  logic [3:0] req_fsize = '0;
  logic [3:0] req_asize = '0;
  logic       done, done_fail, done_err;
  logic [5:0] done_base;

  always #5 clk = ~clk;

  blk_alloc #(.POOL_WORDS(M), .MAX_REQ(MX)) u_blk_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_fsize(req_fsize),
    .req_asize(req_asize), .done(done), .done_base(done_base),
    .done_fail(done_fail), .done_err(done_err)
  );

  int compared = 0, mismatched = 0;
  bit finished = 0;
  bit fw [M];
  int lv_b [64];
  int lv_s [64];
  int nlive = 0;

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int mdl_fit(int sz);
    int best = -1, blen = M + 1, i = 0;
    while (i < M) begin
      if (fw[i]) begin
        int j = i;
        while (j < M && fw[j]) j++;
        if (j - i >= sz && j - i < blen) begin best = i; blen = j - i; end
        i = j;
      end else i++;
    end
    return best;
  endfunction

  function automatic void mdl_mark(int b, int s, bit val);
    for (int k = b; k < b + s; k++) fw[k] = val;
  endfunction

  task automatic run_req(int op, int asz, int fsz, int base,
                         output int act_base, output bit ok);
    bit e_err, e_fail, save [M];
    int e_base, e_lat, lat;
    bit got;
    string tag;
    e_err  = (op == 3) || (op != 1 && (asz < 1 || asz > MX)) ||
             (op != 0 && (fsz < 1 || fsz > MX || base + fsz > M));
    e_fail = 0; e_base = 0; e_lat = 1;
    if (e_err) begin
      tag = ((op == 3) || (op != 1 && (asz < 1 || asz > MX))) ? "R3" : "R4";
    end else if (op == 0) begin
      e_lat = 2; e_base = mdl_fit(asz);
      e_fail = (e_base < 0);
      if (e_fail) e_base = 0; else mdl_mark(e_base, asz, 0);
      tag = e_fail ? "R6" : "R5";
    end else if (op == 1) begin
      e_lat = 2; mdl_mark(base, fsz, 1); e_base = base; tag = "R7";
    end else begin
      e_lat = 3; save = fw; mdl_mark(base, fsz, 1);
      e_base = mdl_fit(asz);
      e_fail = (e_base < 0);
      if (e_fail) begin fw = save; e_base = 0; end
      else mdl_mark(e_base, asz, 0);
      tag = "R8";
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_asize = 4'(asz);
    req_fsize = 4'(fsz); req_base = 6'(base);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0; got = 0; act_base = 0;
    while (lat < 50 && !got) begin
      @(negedge clk);
      lat++;
      if (lat == 1) chk("R2", "ready after accept", int'(req_ready), 0);
      if (done) begin
        got = 1;
        act_base = int'(done_base);
        chk(tag, "err flag", int'(done_err), int'(e_err));
        chk(tag, "fail flag", int'(done_fail), int'(e_fail));
        chk("R9", {tag, " base"}, act_base, e_base);
        chk("R10", "latency", lat, e_lat);
      end
    end
    if (!got) chk("R2", "done never seen", 0, 1);
    @(negedge clk);
    chk("R2", "done width", int'(done), 0);
    ok = !e_err && !e_fail;
  endtask

  task automatic do_alloc(int asz);
    int b; bit ok;
    run_req(0, asz, 0, 0, b, ok);
    if (ok) begin lv_b[nlive] = b; lv_s[nlive] = asz; nlive++; end
  endtask

  task automatic do_free(int k);
    int b; bit ok;
    run_req(1, 0, lv_s[k], lv_b[k], b, ok);
    nlive--; lv_b[k] = lv_b[nlive]; lv_s[k] = lv_s[nlive];
  endtask

  task automatic do_swap(int k, int asz);
    int b; bit ok;
    run_req(2, asz, lv_s[k], lv_b[k], b, ok);
    if (ok) begin lv_b[k] = b; lv_s[k] = asz; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int b; bit ok;
    void'($urandom(32'h1F2E3D4C));
    for (int k = 0; k < M; k++) fw[k] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "ready after reset", int'(req_ready), 1);
    chk("R2", "done after reset", int'(done), 0);

    // R1: whole pool free, first block at 0
    run_req(0, 8, 0, 0, b, ok);
    chk("R1", "first alloc base", b, 0);
    lv_b[0] = b; lv_s[0] = 8; nlive = 1;
    do_alloc(8); do_alloc(8);
    do_free(1);            // hole of 8 words at base 8
    do_alloc(4);           // R5 best fit into the hole
    do_free(1);            // R7 merges with both neighbours

    // R3 / R4 malformed requests
    run_req(0, 0, 0, 0, b, ok);
    run_req(0, 9, 0, 0, b, ok);
    run_req(3, 2, 2, 0, b, ok);
    run_req(1, 0, 8, 60, b, ok);
    run_req(1, 0, 0, 0, b, ok);
    run_req(1, 0, 9, 0, b, ok);
    run_req(2, 0, 2, 0, b, ok);

    // R6 exhaustion, then R8 replace that cannot fit
    for (int k = 0; k < 12; k++) do_alloc(8);
    for (int k = 0; k < 10; k++) do_alloc(1);
    do_alloc(1);
    if (nlive > 0) do_swap(nlive - 1, 8);
    do_alloc(2);
    while (nlive > 0) do_free(0);

    // random mix
    for (int n = 0; n < 700; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 5) begin
        int sel = $urandom_range(0, 2);
        if (sel == 0) run_req(3, 1, 1, 0, b, ok);
        else if (sel == 1) run_req(0, $urandom_range(9, 15), 0, 0, b, ok);
        else run_req(1, 0, 8, $urandom_range(57, 63), b, ok);
      end else if (r < 42 && nlive > 0) begin
        do_free($urandom_range(0, nlive - 1));
      end else if (r < 62 && nlive > 0) begin
        do_swap($urandom_range(0, nlive - 1), $urandom_range(1, MX));
      end else begin
        do_alloc($urandom_range(1, MX));
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule